// File: doc/BRIEF.md
# SPI Burst Master with Per-Word Chip Select

This block is a full-duplex SPI master that moves a burst of 32-bit words to and from a single slave. Chip select is released between every word for a counted number of SCLK periods. Before each word, chip select is driven low a fixed number of periods ahead of the first bit. After the last bit, it is held low for a fixed number of periods. A burst starts on a one-cycle trigger pulse, or on a tick from an internal periodic timer, so that whole bursts repeat at a fixed rate without host involvement.

Transmit words come from a small word-addressed transmit buffer. Word i of a burst always sends buffer entry i. Every received word is pushed into a receive FIFO, and a host drains the FIFO later in batches. SCLK is the system clock divided by an even parameter `DIV`. With a 100 MHz clock and `DIV`=4, SCLK runs at 25 MHz. With 20 words per burst, one burst fits inside a 30 kHz repetition period.

Two conditions raise sticky flags, which are cleared only by reset. A start request that arrives while a burst is running sets one flag. A received word that finds the FIFO full sets the other.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, cs_n=1, sclk=0, busy=0, done=0, overrun=0, rx_ovf=0, rx_empty=1 and rx_level=0.
- R2: A start request is trig=1, or a timer tick.
  - A start request in idle with a nonzero burst_len drops cs_n and raises busy at the next clock edge.
  - burst_len=0 starts nothing.
  - A burst_len above MAX_WORDS runs exactly MAX_WORDS words.
- R3: Each word has 32 bits and uses SPI mode 0.
  - Bits are sent MSB first.
  - sclk idles low and has a period of DIV clocks, high for DIV/2 of them.
  - mosi changes only on falling sclk.
  - miso is sampled on rising sclk.
  - sclk stays low whenever cs_n=1.
- R4: cs_n goes low SETUP_SCLK*DIV+DIV/2 clocks before the first rising sclk of a word. It rises HOLD_SCLK*DIV clocks after that word's last falling sclk.
- R5: Between two words of one burst, cs_n stays high for exactly GAP_SCLK*DIV clocks.
- R6: Word i of a burst (counting from 0) transmits transmit-buffer entry i. Entries are written with tx_wr, tx_addr and tx_data.
- R7: Received words enter the FIFO in arrival order.
  - rx_data shows the oldest word while rx_empty=0.
  - rx_rd=1 removes that word.
  - rx_level counts the stored words and never exceeds RX_DEPTH.
- R8: A word that completes while the FIFO holds RX_DEPTH words is discarded, and rx_ovf becomes 1 and stays 1. The stored words are left unchanged.
- R9: A start request while busy=1 does not start or lengthen a burst, and overrun becomes 1 and stays 1.
- R10: done is a one-cycle pulse in the cycle where cs_n rises after the last word of a burst. busy is 0 in that cycle.
- R11: With timer_en=1 and period=P>0, a start request occurs every P clocks. Successive done pulses of equal-length bursts are therefore exactly P clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | One-cycle burst start request |
| timer_en | input | 1 | Enables the periodic start timer |
| period | input | PERIOD_W | Timer period in clocks (0 = no ticks) |
| burst_len | input | $clog2(MAX_WORDS+1) | Words per burst, latched at start |
| tx_wr | input | 1 | Transmit-buffer write strobe |
| tx_addr | input | $clog2(MAX_WORDS) | Transmit-buffer entry index |
| tx_data | input | 32 | Transmit-buffer write data |
| rx_rd | input | 1 | Pops the oldest received word |
| rx_data | output | 32 | Oldest received word |
| rx_empty | output | 1 | Receive FIFO is empty |
| rx_level | output | $clog2(RX_DEPTH)+1 | Words held in the receive FIFO |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low slave select |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| overrun | output | 1 | Sticky: start request arrived while busy |
| rx_ovf | output | 1 | Sticky: word dropped on a full FIFO |

## Verification
The main function is tried with four input patterns:
- A single-word burst with distinct nibble patterns in each direction. This separates bit order and sampling-edge errors from framing errors.
- A three-word burst with different words. This exposes wrong buffer indexing, FIFO reordering and a miscounted inter-word gap.
- Timer-driven bursts back to back, measured against each other. This tells an off-by-one timer period from a correct one.
- An oversized length request that fills the FIFO exactly, followed by one more burst. This distinguishes length clamping from FIFO-full dropping.

A zero-length request and a trigger in mid-burst show that ignored starts leave the pins and the burst count untouched.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } seq_state_e;

  // Converts a duration in SCLK periods into system clock cycles.
  function automatic int unsigned sys_ticks(input int unsigned sclk_periods,
                                            input int unsigned div);
    return sclk_periods * div;
  endfunction

  // Limits a requested word count to the transmit buffer size.
  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned max_words);
    return (req > max_words) ? max_words : req;
  endfunction

endpackage

// File: rtl/spi_rate_timer.sv
module spi_rate_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);

  logic [PERIOD_W-1:0] cnt;

  assign tick = en && (period != '0) && (cnt >= period - PERIOD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + PERIOD_W'(1);
  end

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_burst_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word
);

  localparam int HALF = DIV / 2;
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BW   = $clog2(WORD_W);

  logic              active;
  logic [PW-1:0]     ph;
  logic [BW-1:0]     bitn;
  logic [WORD_W-1:0] txsh;
  logic [WORD_W-1:0] rxsh;

  wire rise_now = active && (ph == PW'(HALF - 1));
  wire fall_now = active && (ph == PW'(DIV - 1));
  wire last_bit = (bitn == BW'(WORD_W - 1));

  assign mosi = txsh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      ph        <= '0;
      bitn      <= '0;
      txsh      <= '0;
      rxsh      <= '0;
      rx_word   <= '0;
      sclk      <= 1'b0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (load) begin
        active <= 1'b1;
        ph     <= '0;
        bitn   <= '0;
        txsh   <= load_word;
        sclk   <= 1'b0;
      end else if (active) begin
        ph <= fall_now ? '0 : ph + PW'(1);
        if (rise_now) begin
          sclk <= 1'b1;
          rxsh <= {rxsh[WORD_W-2:0], miso};
        end
        if (fall_now) begin
          sclk <= 1'b0;
          if (last_bit) begin
            active    <= 1'b0;
            word_done <= 1'b1;
            rx_word   <= rxsh;
          end else begin
            bitn <= bitn + BW'(1);
            txsh <= {txsh[WORD_W-2:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [W-1:0]           push_data,
  input  logic                   pop,
  output logic [W-1:0]           pop_data,
  output logic                   empty,
  output logic                   drop,
  output logic [$clog2(DEPTH):0] level
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  wire full     = (level == LW'(DEPTH));
  wire do_push  = push && !full;
  wire do_pop   = pop && !empty;

  assign empty    = (level == '0);
  assign drop     = push && full;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int DIV        = 4,
  parameter int SETUP_SCLK = 2,
  parameter int HOLD_SCLK  = 3,
  parameter int GAP_SCLK   = 3,
  parameter int MAX_WORDS  = 32,
  parameter int RX_DEPTH   = 32,
  parameter int PERIOD_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          trig,
  input  logic                          timer_en,
  input  logic [PERIOD_W-1:0]           period,
  input  logic [$clog2(MAX_WORDS+1)-1:0] burst_len,
  input  logic                          tx_wr,
  input  logic [$clog2(MAX_WORDS)-1:0]  tx_addr,
  input  logic [31:0]                   tx_data,
  input  logic                          rx_rd,
  output logic [31:0]                   rx_data,
  output logic                          rx_empty,
  output logic [$clog2(RX_DEPTH):0]     rx_level,
  output logic                          sclk,
  output logic                          mosi,
  input  logic                          miso,
  output logic                          cs_n,
  output logic                          busy,
  output logic                          done,
  output logic                          overrun,
  output logic                          rx_ovf
);

  localparam int LEN_W   = $clog2(MAX_WORDS + 1);
  localparam int IDX_W   = $clog2(MAX_WORDS);
  localparam int TMR_W   = 16;
  localparam int SETUP_T = sys_ticks(SETUP_SCLK, DIV);
  localparam int HOLD_T  = sys_ticks(HOLD_SCLK, DIV);
  localparam int GAP_T   = sys_ticks(GAP_SCLK, DIV);

  seq_state_e        state;
  logic [TMR_W-1:0]  tmr;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  idx;
  logic              cs_q;
  logic              done_q;
  logic              ovr_q;
  logic              ovf_q;
  logic [WORD_W-1:0] txbuf [MAX_WORDS];

  // Named internal events, also observed by the bound checker.
  logic              tick;
  logic              start_req;
  logic              start_ok;
  logic              start_rej;
  logic              word_end;
  logic              load_word;
  logic              fifo_drop;
  logic [WORD_W-1:0] rx_word;
  logic [LEN_W-1:0]  eff_len;

  assign eff_len   = LEN_W'(clamp_len(int'(burst_len), MAX_WORDS));
  assign start_req = trig || tick;
  assign start_ok  = start_req && (state == ST_IDLE) && (eff_len != '0);
  assign start_rej = start_req && (state != ST_IDLE);
  assign load_word = (state == ST_SETUP) && (tmr == '0);

  wire tmr_zero  = (tmr == '0);
  wire last_word = (idx == len_q - LEN_W'(1));

  spi_rate_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (timer_en),
    .period (period),
    .tick   (tick)
  );

  spi_word_shifter #(.DIV(DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_word),
    .load_word (txbuf[idx[IDX_W-1:0]]),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .word_done (word_end),
    .rx_word   (rx_word)
  );

  spi_rx_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (word_end),
    .push_data (rx_word),
    .pop       (rx_rd),
    .pop_data  (rx_data),
    .empty     (rx_empty),
    .drop      (fifo_drop),
    .level     (rx_level)
  );

  always_ff @(posedge clk) begin
    if (tx_wr) txbuf[tx_addr] <= tx_data;
  end

  // Burst sequencer: setup -> shift -> hold -> (gap -> setup ...)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tmr    <= '0;
      len_q  <= '0;
      idx    <= '0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_rej) ovr_q <= 1'b1;
      if (fifo_drop) ovf_q <= 1'b1;
      case (state)
        ST_IDLE: if (start_ok) begin
          len_q <= eff_len;
          idx   <= '0;
          tmr   <= TMR_W'(SETUP_T - 1);
          cs_q  <= 1'b0;
          state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (tmr_zero) state <= ST_SHIFT;
          else          tmr   <= tmr - TMR_W'(1);
        end
        ST_SHIFT: if (word_end) begin
          // One cycle already elapsed since the last falling edge.
          tmr   <= TMR_W'(HOLD_T - 2);
          state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (tmr_zero) begin
            cs_q <= 1'b1;
            if (last_word) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              idx   <= idx + LEN_W'(1);
              tmr   <= TMR_W'(GAP_T - 1);
              state <= ST_GAP;
            end
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        ST_GAP: begin
          if (tmr_zero) begin
            cs_q  <= 1'b0;
            tmr   <= TMR_W'(SETUP_T - 1);
            state <= ST_SETUP;
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs_n    = cs_q;
  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign overrun = ovr_q;
  assign rx_ovf  = ovf_q;

endmodule

// File: rtl/spi_burst_checks.sv
module spi_burst_checks #(
  parameter int DIV      = 4,
  parameter int GAP_T    = 12,
  parameter int RX_DEPTH = 32,
  parameter int LVL_W    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             busy,
  input logic             done,
  input logic             overrun,
  input logic             rx_ovf,
  input logic [LVL_W-1:0] rx_level,
  input logic             start_req,
  input logic             word_end
);

  // Counts consecutive cycles with chip select released.
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_cnt <= '0;
    else if (!cs_n)            hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  assert_sclk_low_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_mosi_stable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_word_end_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |-> !cs_n);

  assert_gap_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && $past(busy)) |-> (hi_cnt >= 16'(GAP_T)));

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LVL_W'(RX_DEPTH));

  assert_rx_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> rx_ovf);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(start_req && busy));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n));

endmodule

bind spi_burst_master spi_burst_checks #(
  .DIV      (DIV),
  .GAP_T    (GAP_T),
  .RX_DEPTH (RX_DEPTH),
  .LVL_W    ($clog2(RX_DEPTH) + 1)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .busy      (busy),
  .done      (done),
  .overrun   (overrun),
  .rx_ovf    (rx_ovf),
  .rx_level  (rx_level),
  .start_req (start_req),
  .word_end  (word_end)
);

// File: tb/tb_spi_burst_master.sv
`timescale 1ns/1ps
module tb_spi_burst_master;

  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int SETUP = 2;
  localparam int HOLD  = 3;
  localparam int GAP   = 3;
  localparam int MAXW  = 32;
  localparam int DEPTH = 32;
  localparam int EXP_LEAD = SETUP * DIV + DIV / 2;
  localparam int EXP_TAIL = HOLD * DIV;
  localparam int EXP_GAP  = GAP * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        timer_en = 1'b0;
  logic [15:0] period = '0;
  logic [5:0]  burst_len = '0;
  logic        tx_wr = 1'b0;
  logic [4:0]  tx_addr = '0;
  logic [31:0] tx_data = '0;
  logic        rx_rd = 1'b0;
  logic [31:0] rx_data;
  logic        rx_empty;
  logic [5:0]  rx_level;
  logic        sclk, mosi, miso, cs_n, busy, done, overrun, rx_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_burst_master dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .timer_en(timer_en),
    .period(period), .burst_len(burst_len), .tx_wr(tx_wr),
    .tx_addr(tx_addr), .tx_data(tx_data), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_empty(rx_empty), .rx_level(rx_level),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy),
    .done(done), .overrun(overrun), .rx_ovf(rx_ovf)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // ---------------- slave model and pin monitor (negedge sampling) -------
  logic [31:0] slave_words [128];
  logic [31:0] rx_log      [128];
  logic [31:0] slv_sh = '0;
  logic [31:0] slv_rx = '0;
  assign miso = slv_sh[31];

  int  cyc = 0, slv_idx = 0, bits = 0, lead = 0, tail = 0, gap_run = 0;
  int  last_rise = 0, dones = 0, done_at_rise = 0, gaps = 0;
  int  done_cyc = 0, prev_done_cyc = 0;
  int  bad_lead = 0, bad_tail = 0, bad_gap = 0, bad_bits = 0, bad_per = 0;
  bit  prev_cs = 1'b1, prev_sclk = 1'b0, got_rise = 1'b0, gap_pending = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (done) begin
      dones++;
      prev_done_cyc = done_cyc;
      done_cyc = cyc;
    end
    if (prev_cs && !cs_n) begin
      if (gap_pending) begin
        gaps++;
        if (gap_run != EXP_GAP) bad_gap++;
      end
      gap_pending = 1'b0;
      got_rise = 1'b0;
      lead = 0;
      bits = 0;
      slv_sh = slave_words[slv_idx];
    end
    if (!cs_n) begin
      if (sclk && !prev_sclk) begin
        if (!got_rise && lead != EXP_LEAD) bad_lead++;
        if (got_rise && (cyc - last_rise) != DIV) bad_per++;
        got_rise = 1'b1;
        last_rise = cyc;
        slv_rx = {slv_rx[30:0], mosi};
        bits++;
      end else if (!sclk && prev_sclk) begin
        slv_sh = {slv_sh[30:0], 1'b0};
        tail = 1;
      end else if (!got_rise) begin
        lead++;
      end else if (!sclk) begin
        tail++;
      end
      if (!got_rise && !(sclk && !prev_sclk)) begin
        // lead counted above when no rise yet
      end
    end
    if (!prev_cs && cs_n) begin
      if (bits != 32) bad_bits++;
      if (tail != EXP_TAIL) bad_tail++;
      rx_log[slv_idx] = slv_rx;
      slv_idx++;
      gap_run = 0;
      gap_pending = !done;
      if (done) done_at_rise++;
    end
    if (cs_n) gap_run++;
    if (cs_n && sclk) bad_per++;
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 200000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", wd, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic write_tx(input int a, input logic [31:0] d);
    @(negedge clk);
    tx_wr = 1'b1; tx_addr = 5'(a); tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic fire(input int len, input string req);
    @(negedge clk);
    burst_len = 6'(len);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    if (len != 0) chk(!cs_n && busy, req, {30'd0, busy, cs_n}, 32'h2);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic pop_chk(input logic [31:0] exp, input string req);
    @(negedge clk);
    chk(!rx_empty && rx_data == exp, req, rx_data, exp);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic timing_chk(input string tag);
    chk(bad_lead == 0, {tag, " R4 setup"}, bad_lead, 0);
    chk(bad_tail == 0, {tag, " R4 hold"}, bad_tail, 0);
    chk(bad_bits == 0 && bad_per == 0, {tag, " R3 framing"}, bad_bits + bad_per, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(cs_n && !sclk && !busy && !done, "R1 pins", {28'd0, cs_n, sclk, busy, done}, 32'h8);
    chk(!overrun && !rx_ovf && rx_empty && rx_level == 0, "R1 flags",
        {24'd0, rx_level, overrun, rx_ovf}, 0);
  endtask

  task automatic t_single();
    int base = slv_idx;
    int d0 = dones;
    write_tx(0, 32'hA5C3_0F96);
    slave_words[base] = 32'h1234_5678;
    fire(1, "R2 start");
    wait_idle();
    chk(rx_log[base] == 32'hA5C3_0F96, "R3 R6 mosi word", rx_log[base], 32'hA5C3_0F96);
    chk(dones == d0 + 1 && done_at_rise == 1, "R10 done pulse", dones - d0, 1);
    timing_chk("single");
    chk(rx_level == 1, "R7 level", rx_level, 1);
    pop_chk(32'h1234_5678, "R3 R7 miso word");
    chk(rx_empty, "R7 empty after pop", rx_empty, 1);
  endtask

  task automatic t_multi();
    int base = slv_idx;
    int g0 = gaps;
    write_tx(0, 32'h0000_0001);
    write_tx(1, 32'h8000_0000);
    write_tx(2, 32'hDEAD_BEEF);
    slave_words[base]   = 32'hF0E1_D2C3;
    slave_words[base+1] = 32'h0F1E_2D3C;
    slave_words[base+2] = 32'h5555_AAAA;
    fire(3, "R2 start multi");
    wait_idle();
    chk(slv_idx - base == 3, "R6 word count", slv_idx - base, 3);
    chk(rx_log[base] == 32'h0000_0001, "R6 word0", rx_log[base], 32'h1);
    chk(rx_log[base+1] == 32'h8000_0000, "R6 word1", rx_log[base+1], 32'h8000_0000);
    chk(rx_log[base+2] == 32'hDEAD_BEEF, "R6 word2", rx_log[base+2], 32'hDEAD_BEEF);
    chk(gaps - g0 == 2 && bad_gap == 0, "R5 gap", bad_gap, 0);
    timing_chk("multi");
    pop_chk(32'hF0E1_D2C3, "R7 order0");
    pop_chk(32'h0F1E_2D3C, "R7 order1");
    pop_chk(32'h5555_AAAA, "R7 order2");
  endtask

  task automatic t_len0();
    int d0 = dones;
    int s0 = slv_idx;
    fire(0, "R2 zero");
    repeat (30) @(negedge clk);
    chk(!busy && cs_n && dones == d0 && slv_idx == s0, "R2 zero length ignored",
        {30'd0, busy, cs_n}, 32'h1);
  endtask

  task automatic t_timer();
    int base = slv_idx;
    int d0 = dones;
    int n = 0;
    write_tx(0, 32'h3C3C_C3C3);
    for (int i = 0; i < 4; i++) slave_words[base + i] = 32'hB000_0000 + i;
    @(negedge clk);
    burst_len = 6'd1;
    period = 16'd500;
    timer_en = 1'b1;
    while (dones < d0 + 3 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    timer_en = 1'b0;
    chk(dones == d0 + 3, "R11 timer bursts", dones - d0, 3);
    chk(done_cyc - prev_done_cyc == 500, "R11 period", done_cyc - prev_done_cyc, 500);
    wait_idle();
    repeat (1200) @(negedge clk);
    chk(dones == d0 + 3, "R11 disabled", dones - d0, 3);
    chk(!overrun, "R9 no overrun", overrun, 0);
    for (int i = 0; i < 3; i++) pop_chk(32'hB000_0000 + i, "R11 R7 timer data");
  endtask

  task automatic t_overrun();
    int base = slv_idx;
    int d0 = dones;
    slave_words[base] = 32'h1111_2222;
    slave_words[base+1] = 32'h3333_4444;
    fire(2, "R2 start ovr");
    repeat (50) @(negedge clk);
    fire(0, "R9");
    @(negedge clk);
    burst_len = 6'd2;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(overrun, "R9 overrun set", overrun, 1);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(slv_idx - base == 2 && dones == d0 + 1 && !busy, "R9 burst unchanged",
        slv_idx - base, 2);
    chk(overrun, "R9 sticky", overrun, 1);
    pop_chk(32'h1111_2222, "R9 R7 data0");
    pop_chk(32'h3333_4444, "R9 R7 data1");
  endtask

  task automatic t_overflow();
    int base = slv_idx;
    for (int i = 0; i < MAXW; i++) write_tx(i, 32'hC000_0000 | i);
    for (int i = 0; i < 34; i++) slave_words[base + i] = 32'h5A00_0000 + i;
    fire(40, "R2 start clamp");
    wait_idle();
    chk(slv_idx - base == MAXW, "R2 clamp to MAX_WORDS", slv_idx - base, MAXW);
    chk(rx_log[base + 31] == 32'hC000_001F, "R6 last entry", rx_log[base + 31], 32'hC000_001F);
    chk(rx_level == DEPTH && !rx_ovf, "R7 full no ovf", rx_level, DEPTH);
    fire(2, "R2 start full");
    wait_idle();
    chk(rx_ovf && rx_level == DEPTH, "R8 overflow", {rx_ovf, 25'd0, rx_level}, 32'h8000_0020);
    pop_chk(32'h5A00_0000, "R8 oldest kept");
    chk(rx_ovf, "R8 sticky", rx_ovf, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_len0();
    t_timer();
    t_overrun();
    t_overflow();
    chk(bad_gap == 0, "R5 all gaps", bad_gap, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule